// File: doc/BRIEF.md
# Chained Byte Stream Cipher (encrypt and decrypt lanes)

This block scrambles and unscrambles the bytes of a command/reply channel. It has two independent lanes. The encrypt lane turns plaintext bytes into ciphertext. The decrypt lane turns ciphertext back into plaintext. Each lane takes one byte per handshake on a valid/ready stream and presents the transformed byte one cycle later on its own valid/ready output.

Each byte passes through two rounds built from modulo-256 additions, subtractions and XORs with fixed constants. The rounds are keyed by two 8-bit chaining registers. The plain-side chain holds the previous plaintext byte. The cipher-side chain holds the previous ciphertext byte. A per-lane frame-start pulse returns both chains to their seed values. A frame holds 1 to 64 bytes.

A typical sequence is: pulse frame start, stream the bytes of one command, pulse again before the next command. The decrypt lane must be restarted at the same frame boundaries as the encrypt lane that produced the data.

Top module: `chain_cipher`

## Requirements
- R1: After reset, both lanes hold their output valid low and their input ready high, and both chains hold their seeds: plain-side 0x9b, cipher-side 0x54.
- R2: The first byte of a frame is encrypted with the seed chains. Plaintext 0x00 as the first byte gives ciphertext 0xda.
- R3: Encryption of byte v, all arithmetic mod 256, with plain-side chain p and cipher-side chain c, is a two-round computation. Round one: a = (((v ^ c ^ 0x2b) - 0x05) ^ 0x35) - 0x39. Round two: y = (((a ^ p ^ 0x5a) - 0xb0) ^ 0x38) - 0x45. After the byte, p becomes v and c becomes y.
- R4: Decryption undoes R3 exactly. After each byte, the plain-side chain becomes the recovered plaintext and the cipher-side chain becomes the received ciphertext byte. As a result, decrypting a frame's ciphertext in a freshly started frame returns the original plaintext.
- R5: A byte accepted at a clock edge appears on the lane output with output valid high after that edge, a latency of exactly one cycle.
- R6: While output valid is high and output ready is low, the output byte and output valid hold, and input ready is low.
- R7: The chains advance only on an accepted byte (input valid and input ready both high). A byte that is offered but not accepted changes nothing.
- R8: A frame-start pulse has priority over a chain update. A byte accepted in the same cycle as the pulse is transformed with the old chains, and the next byte is transformed with the seeds.
- R9: Frames of every length from 1 to 64 bytes round-trip through the encrypt lane and then the decrypt lane unchanged. A frame accepts at most 64 bytes between frame-start pulses.
- R10: A frame-start pulse with no byte, given mid-frame, restarts the chains. The following byte is encrypted as in R2 and decrypted back accordingly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_frame_start | input | 1 | Reload the encrypt lane's chains to their seeds |
| enc_in_valid | input | 1 | Plaintext byte offered |
| enc_in_data | input | 8 | Plaintext byte |
| enc_in_ready | output | 1 | Encrypt lane can accept a byte |
| enc_out_valid | output | 1 | Ciphertext byte present |
| enc_out_data | output | 8 | Ciphertext byte |
| enc_out_ready | input | 1 | Consumer takes the ciphertext byte |
| dec_frame_start | input | 1 | Reload the decrypt lane's chains to their seeds |
| dec_in_valid | input | 1 | Ciphertext byte offered |
| dec_in_data | input | 8 | Ciphertext byte |
| dec_in_ready | output | 1 | Decrypt lane can accept a byte |
| dec_out_valid | output | 1 | Recovered plaintext byte present |
| dec_out_data | output | 8 | Recovered plaintext byte |
| dec_out_ready | input | 1 | Consumer takes the plaintext byte |

## Verification
The hardest case to reach from the ports is a frame-start pulse landing in the same cycle as an accepted byte. Whether that byte sees the old or the seeded chains changes every later byte of the stream. The stimulus holds a byte valid while raising the pulse in that same cycle, then sends a further byte and compares both results with a model that chains the first byte on the old state and the second on the seeds. A second hard case is a stall: a byte is held offered while output ready is low. The bench checks that the byte accepted afterwards is chained on exactly one predecessor, not two.

// File: rtl/chain_cipher_pkg.sv
package chain_cipher_pkg;

  localparam int BYTE_W = 8;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef struct packed {
    byte_t pchain;   // previous plaintext
    byte_t cchain;   // previous ciphertext
  } chain_t;

  typedef enum logic { DIR_ENC = 1'b0, DIR_DEC = 1'b1 } dir_e;

  localparam byte_t PCHAIN_SEED = 8'h9b;
  localparam byte_t CCHAIN_SEED = 8'h54;

  function automatic chain_t seed_chain();
    chain_t s;
    s.pchain = PCHAIN_SEED;
    s.cchain = CCHAIN_SEED;
    return s;
  endfunction

  // forward round keyed by the ciphertext chain
  function automatic byte_t fwd_round_c(byte_t v, byte_t c);
    byte_t t;
    t = v ^ c ^ 8'h2b;
    t = t - 8'h05;
    t = t ^ 8'h35;
    t = t - 8'h39;
    return t;
  endfunction

  // forward round keyed by the plaintext chain
  function automatic byte_t fwd_round_p(byte_t a, byte_t p);
    byte_t t;
    t = a ^ p ^ 8'h5a;
    t = t - 8'hb0;
    t = t ^ 8'h38;
    t = t - 8'h45;
    return t;
  endfunction

  function automatic byte_t inv_round_p(byte_t y, byte_t p);
    byte_t t;
    t = y + 8'h45;
    t = t ^ 8'h38;
    t = t + 8'hb0;
    t = t ^ 8'h5a ^ p;
    return t;
  endfunction

  function automatic byte_t inv_round_c(byte_t a, byte_t c);
    byte_t t;
    t = a + 8'h39;
    t = t ^ 8'h35;
    t = t + 8'h05;
    t = t ^ 8'h2b ^ c;
    return t;
  endfunction

  function automatic byte_t encrypt_byte(byte_t v, chain_t st);
    return fwd_round_p(fwd_round_c(v, st.cchain), st.pchain);
  endfunction

  function automatic byte_t decrypt_byte(byte_t y, chain_t st);
    return inv_round_c(inv_round_p(y, st.pchain), st.cchain);
  endfunction

endpackage

// File: rtl/chain_state.sv
module chain_state
  import chain_cipher_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   reload,
  input  logic   advance,
  input  chain_t nxt,
  output chain_t cur
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cur <= seed_chain();
    else if (reload)  cur <= seed_chain();
    else if (advance) cur <= nxt;
  end

  AST_RELOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (cur.pchain == PCHAIN_SEED && cur.cchain == CCHAIN_SEED)); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload && !advance) |=> $stable(cur)); // R7

endmodule

// File: rtl/byte_xform.sv
module byte_xform
  import chain_cipher_pkg::*;
#(
  parameter dir_e DIR = DIR_ENC
) (
  input  byte_t  in_byte,
  input  chain_t st,
  output byte_t  out_byte,
  output chain_t nxt
);

  generate
    if (DIR == DIR_ENC) begin : g_enc
      always_comb begin
        out_byte   = encrypt_byte(in_byte, st);
        nxt.pchain = in_byte;
        nxt.cchain = out_byte;
      end
    end else begin : g_dec
      always_comb begin
        out_byte   = decrypt_byte(in_byte, st);
        nxt.pchain = out_byte;
        nxt.cchain = in_byte;
      end
    end
  endgenerate

endmodule

// File: rtl/out_stage.sv
module out_stage
  import chain_cipher_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  byte_t load_data,
  input  logic  out_ready,
  output logic  room,
  output logic  out_valid,
  output byte_t out_data
);

  assign room = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= load_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_OUT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R6

  AST_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !load) |=> !out_valid); // R5

endmodule

// File: rtl/frame_tracker.sv
module frame_tracker #(
  parameter int MAX_FRAME = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic accept
);

  localparam int POS_W = $clog2(MAX_FRAME + 1);

  logic [POS_W-1:0] pos;
  logic             frame_full;

  assign frame_full = (pos == POS_W'(MAX_FRAME));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      pos <= '0;
    else if (restart)                pos <= '0;
    else if (accept && !frame_full)  pos <= pos + 1'b1;
  end

  AST_FRAME_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> !frame_full); // R9

endmodule

// File: rtl/cipher_lane.sv
module cipher_lane
  import chain_cipher_pkg::*;
#(
  parameter dir_e DIR       = DIR_ENC,
  parameter int   MAX_FRAME = 64
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  frame_start,
  input  logic  in_valid,
  input  byte_t in_data,
  output logic  in_ready,
  output logic  out_valid,
  output byte_t out_data,
  input  logic  out_ready
);

  chain_t cur_chain;
  chain_t nxt_chain;
  byte_t  result;
  logic   accept;

  assign accept = in_valid && in_ready;

  chain_state u_state (
    .clk     (clk),
    .rst_n   (rst_n),
    .reload  (frame_start),
    .advance (accept),
    .nxt     (nxt_chain),
    .cur     (cur_chain)
  );

  byte_xform #(.DIR(DIR)) u_xform (
    .in_byte  (in_data),
    .st       (cur_chain),
    .out_byte (result),
    .nxt      (nxt_chain)
  );

  out_stage u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_data (result),
    .out_ready (out_ready),
    .room      (in_ready),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  frame_tracker #(.MAX_FRAME(MAX_FRAME)) u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (frame_start),
    .accept  (accept)
  );

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (out_valid && out_data == $past(result))); // R5

  generate
    if (DIR == DIR_ENC) begin : g_enc_chk
      AST_ENC_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !frame_start) |=> (cur_chain.pchain == $past(in_data) &&
                                      cur_chain.cchain == out_data)); // R3
      AST_ENC_INVERT: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (decrypt_byte(result, cur_chain) == in_data)); // R4
    end else begin : g_dec_chk
      AST_DEC_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !frame_start) |=> (cur_chain.cchain == $past(in_data) &&
                                      cur_chain.pchain == out_data)); // R4
      AST_DEC_INVERT: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (encrypt_byte(result, cur_chain) == in_data)); // R4
    end
  endgenerate

endmodule

// File: rtl/chain_cipher.sv
module chain_cipher
  import chain_cipher_pkg::*;
#(
  parameter int MAX_FRAME = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enc_frame_start,
  input  logic       enc_in_valid,
  input  logic [7:0] enc_in_data,
  output logic       enc_in_ready,
  output logic       enc_out_valid,
  output logic [7:0] enc_out_data,
  input  logic       enc_out_ready,
  input  logic       dec_frame_start,
  input  logic       dec_in_valid,
  input  logic [7:0] dec_in_data,
  output logic       dec_in_ready,
  output logic       dec_out_valid,
  output logic [7:0] dec_out_data,
  input  logic       dec_out_ready
);

  cipher_lane #(.DIR(DIR_ENC), .MAX_FRAME(MAX_FRAME)) u_enc_lane (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (enc_frame_start),
    .in_valid    (enc_in_valid),
    .in_data     (enc_in_data),
    .in_ready    (enc_in_ready),
    .out_valid   (enc_out_valid),
    .out_data    (enc_out_data),
    .out_ready   (enc_out_ready)
  );

  cipher_lane #(.DIR(DIR_DEC), .MAX_FRAME(MAX_FRAME)) u_dec_lane (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (dec_frame_start),
    .in_valid    (dec_in_valid),
    .in_data     (dec_in_data),
    .in_ready    (dec_in_ready),
    .out_valid   (dec_out_valid),
    .out_data    (dec_out_data),
    .out_ready   (dec_out_ready)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> (!enc_out_valid && !dec_out_valid) || rst_n); // R1

endmodule

// File: tb/chain_cipher_bench.sv
module chain_cipher_bench;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic       rst_n;
  logic       enc_frame_start, enc_in_valid, enc_in_ready, enc_out_valid, enc_out_ready;
  logic [7:0] enc_in_data, enc_out_data;
  logic       dec_frame_start, dec_in_valid, dec_in_ready, dec_out_valid, dec_out_ready;
  logic [7:0] dec_in_data, dec_out_data;

  chain_cipher u_chain_cipher (
    .clk(clk), .rst_n(rst_n),
    .enc_frame_start(enc_frame_start), .enc_in_valid(enc_in_valid),
    .enc_in_data(enc_in_data), .enc_in_ready(enc_in_ready),
    .enc_out_valid(enc_out_valid), .enc_out_data(enc_out_data),
    .enc_out_ready(enc_out_ready),
    .dec_frame_start(dec_frame_start), .dec_in_valid(dec_in_valid),
    .dec_in_data(dec_in_data), .dec_in_ready(dec_in_ready),
    .dec_out_valid(dec_out_valid), .dec_out_data(dec_out_data),
    .dec_out_ready(dec_out_ready)
  );

  int n_checks = 0;
  int n_fails  = 0;

  // model chains of the encrypt side
  logic [7:0] m_prev_plain, m_prev_cipher;
  logic [31:0] rng;

  // table: {frame length, seed}
  localparam logic [15:0] VEC [0:7] = '{
    {8'd1,  8'h3c}, {8'd2,  8'h01}, {8'd5,  8'ha7}, {8'd16, 8'h55},
    {8'd31, 8'hf0}, {8'd32, 8'h0e}, {8'd63, 8'h99}, {8'd64, 8'hc3}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_prev_plain  = 8'h9b;
    m_prev_cipher = 8'h54;
  endtask

  // R3: two rounds, then chains take plaintext and ciphertext
  task automatic model_enc(input logic [7:0] v, output logic [7:0] y);
    logic [7:0] a;
    a = v ^ m_prev_cipher;
    a = a ^ 8'h2b;
    a = a + 8'hfb;            // minus 0x05
    a = a ^ 8'h35;
    a = a + 8'hc7;            // minus 0x39
    a = a ^ m_prev_plain ^ 8'h5a;
    a = a + 8'h50;            // minus 0xb0
    a = a ^ 8'h38;
    y = a + 8'hbb;            // minus 0x45
    m_prev_plain  = v;
    m_prev_cipher = y;
  endtask

  task automatic rand_byte(output logic [7:0] b);
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    b = rng[15:8];
  endtask

  task automatic enc_frame();
    @(negedge clk); enc_frame_start = 1'b1;
    @(negedge clk); enc_frame_start = 1'b0;
    model_reset();
  endtask

  task automatic dec_frame();
    @(negedge clk); dec_frame_start = 1'b1;
    @(negedge clk); dec_frame_start = 1'b0;
  endtask

  task automatic enc_send(input logic [7:0] v, output logic [7:0] y);
    @(negedge clk); enc_in_valid = 1'b1; enc_in_data = v;
    @(posedge clk);
    @(negedge clk); enc_in_valid = 1'b0;
    check("R5 enc valid", {7'd0, enc_out_valid}, 8'd1);
    y = enc_out_data;
  endtask

  task automatic dec_send(input logic [7:0] c, output logic [7:0] p);
    @(negedge clk); dec_in_valid = 1'b1; dec_in_data = c;
    @(posedge clk);
    @(negedge clk); dec_in_valid = 1'b0;
    check("R5 dec valid", {7'd0, dec_out_valid}, 8'd1);
    p = dec_out_data;
  endtask

  task automatic run_frame(input int len, input logic [7:0] seed);
    logic [7:0] pt [64];
    logic [7:0] ct [64];
    logic [7:0] got, exp;
    rng = {seed, 8'h5a, ~seed, 8'h1d};
    enc_frame();
    for (int i = 0; i < len; i++) begin
      rand_byte(pt[i]);
      enc_send(pt[i], got);
      model_enc(pt[i], exp);
      check("R3 ciphertext", got, exp);
      ct[i] = got;
    end
    dec_frame();
    for (int i = 0; i < len; i++) begin
      dec_send(ct[i], got);
      check("R4/R9 round trip", got, pt[i]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog R9 actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    logic [7:0] y, e, ya;
    rst_n = 1'b0;
    enc_frame_start = 0; enc_in_valid = 0; enc_in_data = 0; enc_out_ready = 1;
    dec_frame_start = 0; dec_in_valid = 0; dec_in_data = 0; dec_out_ready = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 enc out_valid", {7'd0, enc_out_valid}, 8'd0);
    check("R1 enc in_ready",  {7'd0, enc_in_ready},  8'd1);
    check("R1 dec out_valid", {7'd0, dec_out_valid}, 8'd0);
    check("R1 dec in_ready",  {7'd0, dec_in_ready},  8'd1);
    // R1: seeds active straight out of reset, no frame pulse
    enc_send(8'h00, y);
    check("R1 seeded after reset", y, 8'hda);

    // R2 literal first byte
    enc_frame();
    enc_send(8'h00, y);
    check("R2 first byte", y, 8'hda);
    dec_frame();
    dec_send(8'hda, y);
    check("R2 decrypt first byte", y, 8'h00);

    // table walk (R3, R4)
    for (int k = 0; k < 8; k++) run_frame(int'(VEC[k][15:8]), VEC[k][7:0]);

    // R9: every length
    for (int len = 1; len <= 64; len++) run_frame(len, 8'(len * 7 + 3));

    // R6 / R7: stall
    enc_frame();
    enc_out_ready = 1'b0;
    enc_send(8'h42, ya);
    model_enc(8'h42, e);
    check("R6 stalled byte", ya, e);
    @(negedge clk); enc_in_valid = 1'b1; enc_in_data = 8'h17;
    check("R6 in_ready low", {7'd0, enc_in_ready}, 8'd0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R6 data held", enc_out_data, ya);
      check("R6 valid held", {7'd0, enc_out_valid}, 8'd1);
    end
    enc_out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk); enc_in_valid = 1'b0;
    model_enc(8'h17, e);
    check("R7 chained once", enc_out_data, e);

    // R8: pulse coincides with accepted byte
    enc_frame();
    enc_send(8'h81, y);
    model_enc(8'h81, e);
    check("R8 lead byte", y, e);
    @(negedge clk); enc_in_valid = 1'b1; enc_in_data = 8'h3e; enc_frame_start = 1'b1;
    @(posedge clk);
    @(negedge clk); enc_in_valid = 1'b0; enc_frame_start = 1'b0;
    model_enc(8'h3e, e);
    check("R8 old chain used", enc_out_data, e);
    model_reset();
    enc_send(8'hc4, y);
    model_enc(8'hc4, e);
    check("R8 seeds after pulse", y, e);

    // R10: mid-frame restart without a byte
    enc_frame();
    for (int i = 0; i < 3; i++) enc_send(8'(i + 9), y);
    enc_frame();
    enc_send(8'h00, y);
    check("R10 enc restart", y, 8'hda);
    dec_frame();
    dec_send(8'h11, y);
    dec_send(8'h22, y);
    dec_frame();
    dec_send(8'hda, y);
    check("R10 dec restart", y, 8'h00);

    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule